// File: doc/BRIEF.md
# Int8 Dot-Product Coprocessor

This unit sits beside a small RISC-V core and takes custom instructions over a valid/wait/ready request handshake, in the style of a pico-core coprocessor port. It holds eight 128-bit vector registers, each carrying sixteen signed bytes, and one 64-bit signed accumulator. Software clears the accumulator, runs one or more sixteen-lane signed multiply-accumulate steps over register pairs, and then reads the accumulator back. The read applies an arithmetic right shift and sends the value to a scalar register. Vector registers are filled from memory and written back to memory through a single 32-bit memory port with a request/acknowledge handshake.

The core stays stalled by the wait output until the instruction finishes, so instructions never overlap. An accumulator read does not change the accumulator. Its destination index comes from a 3-bit field, so only scalar registers 0 to 7 can receive it. Vector memory accesses always go to the 16-byte block that contains the base address, and a misaligned base raises no fault.

Top module: `dotp_coproc`

## Requirements
- R1: Eight 128-bit vector registers hold data. A vector loaded from memory and later stored returns the same sixteen bytes.
- R2: The clear instruction sets the accumulator to zero, and a following read with shift 0 returns 0.
- R3: A multiply-accumulate forms the sum of the sixteen products of signed byte lanes (lane i is bits 8i+7..8i) of registers insn[17:15] and insn[22:20], and adds it to the accumulator.
- R4: An accumulator read returns the low 32 bits of the accumulator arithmetically shifted right by insn[25:20] (0 to 63), and leaves the accumulator unchanged.
- R5: Only a read completes with cop_wr high. Its cop_wr_idx is {2'b00, insn[9:7]}, so the destination is always 0 to 7.
- R6: After reset, wait, ready and mem_req are low. A claimed instruction holds cop_wait high from the claim cycle through its completion cycle, and cop_ready is high for exactly one cycle.
- R7: A vector load or store makes exactly four 32-bit beats. Beat k uses address {rs1[31:4], k[1:0], 2'b00} and carries lanes 4k..4k+3 (vector bits 32k+31..32k). The low four bits of rs1 are ignored. A beat's address holds steady until it is acknowledged.
- R8: Decode takes opcode insn[6:0] = 7'b0001011 and funct3 insn[14:12]: 000 clear, 001 multiply-accumulate, 010 read, 011 load, 100 store. Load and store use register insn[9:7] and base rs1. Any other opcode or funct3 is not claimed: wait and ready stay low and no state changes.
- R9: The accumulator keeps all 64 bits, so sums beyond the 32-bit range appear correctly in shifted reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cop_valid | input | 1 | Core presents an instruction |
| cop_insn | input | 32 | Instruction word |
| cop_rs1 | input | 32 | First scalar operand (memory base) |
| cop_wait | output | 1 | Instruction claimed, core must stall |
| cop_ready | output | 1 | Instruction complete |
| cop_wr | output | 1 | Write-back strobe for the scalar result |
| cop_wr_idx | output | 5 | Destination scalar register number |
| cop_rd | output | 32 | Scalar result |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_ack | input | 1 | Beat acknowledged |

## Verification
Two events can land in the same clock edge. The memory acknowledge of the last beat can coincide with the change of state into completion, and the core's request line is still high in the completion cycle. The bench provokes both with random acknowledge latency, including zero wait states (back-to-back acknowledges), and by holding the request until ready is seen. It judges them by counting the beats and their addresses for each instruction, and by comparing every read result against a model. A duplicated beat or a re-executed multiply-accumulate would show up as a wrong count or a wrong sum.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
  localparam int XLEN  = 32;
  localparam int VLEN  = 128;
  localparam int LANE  = 8;
  localparam int ACCW  = 64;
  localparam int NREGS = 8;
  localparam int LANES = VLEN / LANE;
  localparam int BEATS = VLEN / XLEN;
  localparam int RIDX  = $clog2(NREGS);
  localparam int BIDX  = $clog2(BEATS);
  localparam logic [6:0] CUSTOM_OPC = 7'b0001011;

  typedef enum logic [2:0] {
    OP_CLR = 3'd0, OP_MAC = 3'd1, OP_RD = 3'd2, OP_VLD = 3'd3, OP_VST = 3'd4
  } op_e;

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_MEM, S_DONE} state_e;

  // Sum of lane products, sign-correct, fits comfortably in 32 bits
  function automatic logic signed [31:0] lane_dot(logic [VLEN-1:0] a, logic [VLEN-1:0] b);
    logic signed [31:0] s;
    logic signed [15:0] p;
    s = '0;
    for (int i = 0; i < LANES; i++) begin
      p = $signed(a[i*LANE +: LANE]) * $signed(b[i*LANE +: LANE]);
      s = s + {{16{p[15]}}, p};
    end
    return s;
  endfunction

  function automatic logic [XLEN-1:0] acc_read(logic [ACCW-1:0] acc, logic [5:0] sh);
    logic signed [ACCW-1:0] t;
    t = $signed(acc) >>> sh;
    return t[XLEN-1:0];
  endfunction
endpackage

// File: rtl/dotp_decode.sv
module dotp_decode
  import dotp_pkg::*;
(
  input  logic [31:0]     insn,
  output logic            legal,
  output op_e             op,
  output logic [RIDX-1:0] vd,
  output logic [RIDX-1:0] va,
  output logic [RIDX-1:0] vb,
  output logic [5:0]      shamt
);
  logic [2:0] f3;
  logic unused_bits;
  assign f3    = insn[14:12];
  assign legal = (insn[6:0] == CUSTOM_OPC) && (f3 <= 3'd4);
  assign op    = op_e'(f3);
  assign vd    = insn[9:7];
  assign va    = insn[17:15];
  assign vb    = insn[22:20];
  assign shamt = insn[25:20];
  assign unused_bits = ^{insn[31:26], insn[19:18], insn[11:10]};
endmodule

// File: rtl/dotp_vregs.sv
module dotp_vregs
  import dotp_pkg::*;
#(
  parameter int N = NREGS,
  parameter int W = VLEN,
  parameter int XW = XLEN
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [$clog2(N)-1:0]  ra,
  input  logic [$clog2(N)-1:0]  rb,
  input  logic [$clog2(N)-1:0]  rc,
  output logic [W-1:0]          qa,
  output logic [W-1:0]          qb,
  output logic [W-1:0]          qc,
  input  logic                  we,
  input  logic [$clog2(N)-1:0]  widx,
  input  logic [$clog2(W/XW)-1:0] wword,
  input  logic [XW-1:0]         wdata
);
  logic [W-1:0] q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) q[i] <= '0;
    end else if (we) begin
      q[widx][wword*XW +: XW] <= wdata;
    end
  end

  assign qa = q[ra];
  assign qb = q[rb];
  assign qc = q[rc];
endmodule

// File: rtl/dotp_acc.sv
module dotp_acc
  import dotp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_en,
  input  logic            mac_en,
  input  logic            rd_en,
  input  logic [VLEN-1:0] va,
  input  logic [VLEN-1:0] vb,
  input  logic [5:0]      shamt,
  output logic [ACCW-1:0] acc_q,
  output logic [XLEN-1:0] rd_val
);
  logic signed [31:0] dot;
  logic [ACCW-1:0]    dot_ext;

  assign dot     = lane_dot(va, vb);
  assign dot_ext = {{(ACCW-32){dot[31]}}, dot};
  assign rd_val  = acc_read(acc_q, shamt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (clr_en) acc_q <= '0;
    else if (mac_en) acc_q <= acc_q + dot_ext;
  end

  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (acc_q == '0));
  assert_read_keeps_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> $stable(acc_q));
endmodule

// File: rtl/dotp_coproc.sv
module dotp_coproc
  import dotp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cop_valid,
  input  logic [31:0] cop_insn,
  input  logic [31:0] cop_rs1,
  output logic        cop_wait,
  output logic        cop_ready,
  output logic        cop_wr,
  output logic [4:0]  cop_wr_idx,
  output logic [31:0] cop_rd,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack
);
  state_e state;
  op_e    op_q, dec_op;
  logic            dec_legal;
  logic [RIDX-1:0] dec_vd, dec_va, dec_vb, vd_q, va_q, vb_q;
  logic [5:0]      dec_sh, sh_q;
  logic [31:4]     base_q;
  logic [BIDX-1:0] beat_q;
  logic [XLEN-1:0] res_q, rd_val;
  logic [VLEN-1:0] qa, qb, qc;
  logic [ACCW-1:0] acc_q;
  logic unused_rs1;

  // Named events
  logic claim, beat_done, last_beat, clr_en, mac_en, rd_en, vld_we;
  assign claim     = (state == S_IDLE) && cop_valid && dec_legal;
  assign beat_done = (state == S_MEM) && mem_ack;
  assign last_beat = beat_done && (beat_q == BIDX'(BEATS-1));
  assign clr_en    = (state == S_EXEC) && (op_q == OP_CLR);
  assign mac_en    = (state == S_EXEC) && (op_q == OP_MAC);
  assign rd_en     = (state == S_EXEC) && (op_q == OP_RD);
  assign vld_we    = beat_done && (op_q == OP_VLD);
  assign unused_rs1 = ^cop_rs1[3:0];

  dotp_decode u_dec (
    .insn(cop_insn), .legal(dec_legal), .op(dec_op),
    .vd(dec_vd), .va(dec_va), .vb(dec_vb), .shamt(dec_sh)
  );

  dotp_vregs u_vregs (
    .clk(clk), .rst_n(rst_n), .ra(va_q), .rb(vb_q), .rc(vd_q),
    .qa(qa), .qb(qb), .qc(qc), .we(vld_we), .widx(vd_q),
    .wword(beat_q), .wdata(mem_rdata)
  );

  dotp_acc u_acc (
    .clk(clk), .rst_n(rst_n), .clr_en(clr_en), .mac_en(mac_en), .rd_en(rd_en),
    .va(qa), .vb(qb), .shamt(sh_q), .acc_q(acc_q), .rd_val(rd_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= OP_CLR;
      vd_q   <= '0;
      va_q   <= '0;
      vb_q   <= '0;
      sh_q   <= '0;
      base_q <= '0;
      beat_q <= '0;
      res_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (claim) begin
          op_q   <= dec_op;
          vd_q   <= dec_vd;
          va_q   <= dec_va;
          vb_q   <= dec_vb;
          sh_q   <= dec_sh;
          base_q <= cop_rs1[31:4];
          beat_q <= '0;
          state  <= (dec_op == OP_VLD || dec_op == OP_VST) ? S_MEM : S_EXEC;
        end
        S_EXEC: begin
          if (rd_en) res_q <= rd_val;
          state <= S_DONE;
        end
        S_MEM: if (beat_done) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cop_wait   = claim || (state != S_IDLE);
  assign cop_ready  = (state == S_DONE);
  assign cop_wr     = cop_ready && (op_q == OP_RD);
  assign cop_wr_idx = {2'b00, vd_q};
  assign cop_rd     = cop_wr ? res_q : '0;
  assign mem_req    = (state == S_MEM);
  assign mem_we     = (op_q == OP_VST);
  assign mem_addr   = {base_q, beat_q, 2'b00};
  assign mem_wdata  = qc[beat_q*XLEN +: XLEN];

  // Checker-side beat counter per instruction
  logic [BIDX:0] ack_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ack_seen <= '0;
    else if (claim)     ack_seen <= '0;
    else if (beat_done) ack_seen <= ack_seen + 1'b1;
  end

  assert_wait_before_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cop_ready |-> $past(cop_wait));
  assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cop_ready |=> !cop_ready);
  assert_four_beats_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_ready && (op_q == OP_VLD || op_q == OP_VST)) |-> (ack_seen == (BIDX+1)'(BEATS)));
  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> $stable(mem_addr));
  assert_unclaimed_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_IDLE) && cop_valid && !dec_legal) |=> (state == S_IDLE) && $stable(acc_q));
endmodule

// File: tb/dotp_coproc_test.sv
module dotp_coproc_test;
  localparam int CLK_PERIOD = 10;
  localparam int BIG_N = 8300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cop_valid = 1'b0;
  logic [31:0] cop_insn = '0, cop_rs1 = '0;
  logic cop_wait, cop_ready, cop_wr;
  logic [4:0] cop_wr_idx;
  logic [31:0] cop_rd;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  dotp_coproc uut (
    .clk(clk), .rst_n(rst_n), .cop_valid(cop_valid), .cop_insn(cop_insn),
    .cop_rs1(cop_rs1), .cop_wait(cop_wait), .cop_ready(cop_ready),
    .cop_wr(cop_wr), .cop_wr_idx(cop_wr_idx), .cop_rd(cop_rd),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [64];
  logic [27:0] exp_base = '0;
  int ack_cnt = 0, dly = 0;
  logic [127:0] qm [8];
  longint accm = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Memory model with random acknowledge latency (R7 address checks)
  initial mem_ack = 1'b0;
  initial mem_rdata = '0;
  always @(negedge clk) begin
    if (!rst_n || !mem_req) begin
      mem_ack = 1'b0;
    end else if (dly == 0) begin
      chk(mem_addr[31:4] == exp_base, "R7 base", longint'(mem_addr[31:4]), longint'(exp_base));
      chk(mem_addr[3:0] == {ack_cnt[1:0], 2'b00}, "R7 beat addr",
          longint'(mem_addr[3:0]), longint'({ack_cnt[1:0], 2'b00}));
      mem_rdata = mem[mem_addr[7:2]];
      if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
      mem_ack = 1'b1;
      ack_cnt++;
      dly = int'($urandom % 3);
    end else begin
      mem_ack = 1'b0;
      dly--;
    end
  end

  function automatic logic [31:0] mk(input logic [2:0] f3, input logic [2:0] d,
                                     input logic [2:0] a, input logic [5:0] b_or_sh);
    logic [31:0] w;
    w = '0;
    w[6:0] = 7'b0001011;
    w[14:12] = f3;
    w[9:7] = d;
    w[17:15] = a;
    w[25:20] = b_or_sh;
    return w;
  endfunction

  function automatic longint ref_dot(input logic [127:0] a, input logic [127:0] b);
    longint s = 0;
    for (int i = 0; i < 16; i++) begin
      byte x, y;
      x = a[8*i +: 8];
      y = b[8*i +: 8];
      s += longint'(x) * longint'(y);
    end
    return s;
  endfunction

  function automatic logic [31:0] ref_read(input longint acc, input int sh);
    longint t;
    t = acc >>> sh;
    return t[31:0];
  endfunction

  task automatic issue(input logic [31:0] i, input logic [31:0] a, output logic wr,
                       output logic [4:0] idx, output logic [31:0] rd, output int acks);
    bit wait_ok;
    wait_ok = 1'b1;
    @(negedge clk);
    #1;
    cop_valid = 1'b1; cop_insn = i; cop_rs1 = a; exp_base = a[31:4]; ack_cnt = 0;
    #1;
    while (!cop_ready) begin
      if (!cop_wait) wait_ok = 1'b0;
      @(negedge clk);
      #1;
    end
    if (!cop_wait) wait_ok = 1'b0;
    wr = cop_wr; idx = cop_wr_idx; rd = cop_rd; acks = ack_cnt;
    cop_valid = 1'b0;
    @(negedge clk);
    #1;
    chk(wait_ok, "R6 wait held", longint'(wait_ok), 1);
    chk(!cop_ready, "R6 single ready", longint'(cop_ready), 0);
  endtask

  task automatic do_mac(input logic [2:0] a, input logic [2:0] b);
    logic wr; logic [4:0] idx; logic [31:0] rd; int acks;
    issue(mk(3'd1, 3'd0, a, {3'b000, b}), 32'h0, wr, idx, rd, acks);
    accm += ref_dot(qm[a], qm[b]);
  endtask

  task automatic do_clr;
    logic wr; logic [4:0] idx; logic [31:0] rd; int acks;
    issue(mk(3'd0, 3'd0, 3'd0, 6'd0), 32'h0, wr, idx, rd, acks);
    chk(wr == 1'b0, "R5 no wr on clear", longint'(wr), 0);
    accm = 0;
  endtask

  task automatic do_read(input logic [2:0] d, input int sh, input string tag);
    logic wr; logic [4:0] idx; logic [31:0] rd, e; int acks;
    issue(mk(3'd2, d, 3'd0, 6'(sh)), 32'h0, wr, idx, rd, acks);
    e = ref_read(accm, sh);
    chk(rd == e, tag, longint'(rd), longint'(e));
    chk(wr == 1'b1 && idx == {2'b00, d}, "R5 wb index", longint'(idx), longint'(d));
  endtask

  task automatic do_vld(input logic [2:0] r, input logic [31:0] addr);
    logic wr; logic [4:0] idx; logic [31:0] rd; int acks;
    issue(mk(3'd3, r, 3'd0, 6'd0), addr, wr, idx, rd, acks);
    chk(acks == 4, "R7 load beats", acks, 4);
    chk(wr == 1'b0, "R5 no wr on load", longint'(wr), 0);
    for (int k = 0; k < 4; k++) qm[r][32*k +: 32] = mem[{addr[7:4], 2'(k)}];
  endtask

  task automatic do_vst(input logic [2:0] r, input logic [31:0] addr);
    logic wr; logic [4:0] idx; logic [31:0] rd; int acks;
    issue(mk(3'd4, r, 3'd0, 6'd0), addr, wr, idx, rd, acks);
    chk(acks == 4, "R7 store beats", acks, 4);
    for (int k = 0; k < 4; k++)
      chk(mem[{addr[7:4], 2'(k)}] == qm[r][32*k +: 32], "R1 R7 store data",
          longint'(mem[{addr[7:4], 2'(k)}]), longint'(qm[r][32*k +: 32]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!cop_wait && !cop_ready && !mem_req, "R6 reset state",
        longint'({cop_wait, cop_ready, mem_req}), 0);

    // R1 R7: load all registers from unaligned bases, store elsewhere
    for (int r = 0; r < 8; r++) do_vld(3'(r), 32'(r*16 + int'($urandom % 16)));
    for (int r = 0; r < 8; r++) do_vst(3'(r), 32'(128 + r*16 + int'($urandom % 16)));

    // R2: clear then read
    do_clr();
    do_read(3'd5, 0, "R2 clear reads zero");

    // R3 R4: random multiply-accumulate and shifted reads
    for (int t = 0; t < 40; t++) begin
      int blk, sh;
      logic [2:0] a, b, d;
      blk = int'($urandom % 16);
      for (int k = 0; k < 4; k++) mem[blk*4 + k] = $urandom;
      do_vld(3'($urandom % 8), 32'(blk*16 + int'($urandom % 16)));
      if ($urandom % 4 == 0) do_clr();
      a = 3'($urandom % 8); b = 3'($urandom % 8); d = 3'($urandom % 8);
      do_mac(a, b);
      if (t % 3 == 0) do_mac(b, a);
      sh = int'($urandom % 41);
      do_read(d, sh, "R3 R4 shifted read");
      do_read(d, sh, "R4 read is non-destructive");
    end

    // R9: sums beyond 32 bits
    for (int k = 0; k < 4; k++) begin mem[k] = 32'h80808080; mem[4+k] = 32'h7f7f7f7f; end
    do_vld(3'd0, 32'h0000_0003);
    do_vld(3'd1, 32'h0000_001c);
    do_clr();
    for (int n = 0; n < BIG_N; n++) do_mac(3'd0, 3'd0);
    do_read(3'd6, 0, "R9 positive low word");
    do_read(3'd7, 32, "R9 positive high word");
    do_read(3'd7, 3, "R9 positive shift 3");
    do_clr();
    for (int n = 0; n < BIG_N; n++) do_mac(3'd0, 3'd1);
    do_read(3'd6, 0, "R9 negative low word");
    do_read(3'd5, 32, "R9 negative sign word");
    do_read(3'd5, 63, "R9 negative shift 63");

    // R8: unclaimed instructions
    for (int v = 0; v < 3; v++) begin
      bit quiet;
      quiet = 1'b1;
      @(negedge clk);
      #1;
      cop_valid = 1'b1;
      cop_insn = (v == 0) ? mk(3'd7, 3'd0, 3'd0, 6'd0)
               : (v == 1) ? mk(3'd5, 3'd1, 3'd0, 6'd0)
               : (mk(3'd0, 3'd0, 3'd0, 6'd0) & 32'hffff_ff80) | 32'h33;
      for (int c = 0; c < 6; c++) begin
        #1;
        if (cop_wait || cop_ready || mem_req) quiet = 1'b0;
        @(negedge clk);
      end
      cop_valid = 1'b0;
      chk(quiet, "R8 not claimed", longint'(quiet), 1);
    end
    do_read(3'd4, 32, "R8 accumulator untouched");

    do_clr();
    do_read(3'd3, 0, "R2 clear after large sum");

    report();
    $finish;
  end
endmodule